// File: doc/BRIEF.md
# Handshaked Word Read Engine

This block carries out a single 16-bit read over a memory bus whose slaves end each transfer by raising a termination signal. The core issues a one-cycle request that carries an address and a class bit: data fetch or program fetch. The engine then drives the bus through up to three phases. First comes an address phase with no data select. Next comes an optional wait phase, in which it polls the three termination inputs. Last comes a select phase, during which the read word is taken in. The engine then returns the word with a one-cycle completion pulse and a small code that names the input which ended the wait.

All phase lengths are counted in half-cycles. A half-cycle is one clock in which the `halfTick` enable is high, so the engine can follow a bus slower than its own clock. A build-time option treats the acknowledge as always present. With that option set, the wait phase is skipped entirely.

Top module: `bus_word_reader`

## Requirements
- R1: After an accepted request, the engine drives an address phase. In it, `addrStrobe` is 1, `wordSelect` is 0 and `busAddr` equals the requested address. The phase lasts exactly `ANNOUNCE_HALF` (4) half-cycle ticks when a termination input is already high on its last tick.
- R2: If all three termination inputs are low on the last tick of the address phase, the engine keeps `addrStrobe` high and `wordSelect` low. It then re-examines the inputs on every `POLL_HALF`-th (2nd) tick.
- R3: The wait ends at the first examination tick on which any of `ackIn`, `periphValidIn` or `busErrIn` is 1. `wordSelect` rises in the following clock.
- R4: With `IMPLICIT_ACK` = 1, the select phase follows the address phase directly even with all termination inputs low, and `doneStatus` is 00.
- R5: The select phase holds `addrStrobe` = 1, `wordSelect` = 1 and the same `busAddr`. It lasts exactly `SELECT_HALF` (4) ticks, and `rdData` is sampled on its last tick.
- R6: `funcClass` is 0 for a data read and 1 for a program read. It holds that value through every cycle of the address, wait and select phases.
- R7: `done` is a single-cycle pulse in the clock after the last select tick. In that cycle `doneData` holds the sampled word and both strobes are 0.
- R8: `doneStatus` reports the ending input as 01 for acknowledge, 10 for valid-peripheral and 11 for bus error. Bus error has priority over valid-peripheral, which has priority over acknowledge.
- R9: A request raised while an access is in progress has no effect: the running access keeps its address and timing, and no second access follows.
- R10: Reset, which is asynchronous and active low, forces the engine idle, with `addrStrobe`, `wordSelect` and `done` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| halfTick | input | 1 | One-clock enable marking a bus half-cycle |
| reqValid | input | 1 | Start a read (accepted only when idle) |
| reqAddr | input | ADDR_W | Read address |
| reqIsProgram | input | 1 | 1 = program read, 0 = data read |
| busAddr | output | ADDR_W | Address driven on the bus |
| funcClass | output | 1 | Access class driven on the bus |
| addrStrobe | output | 1 | Address valid on the bus |
| wordSelect | output | 1 | Word data select |
| ackIn | input | 1 | Slave acknowledge |
| periphValidIn | input | 1 | Valid-peripheral termination |
| busErrIn | input | 1 | Bus-error termination |
| rdData | input | DATA_W | Read data from the bus |
| done | output | 1 | Completion pulse |
| doneData | output | DATA_W | Captured read word |
| doneStatus | output | 2 | Code of the input that ended the wait |

## Verification
A corrupted phase counter shows up at the ports within one access. The number of ticks during which `addrStrobe` is high without `wordSelect` stops matching 4 + 2k, or the select window is not 4 ticks long, and `done` moves by the same amount. A stray phase state or a lost latch shows up as `busAddr` or `funcClass` changing in the middle of an access, or as a second access appearing after a request that should have been ignored, within a few clocks of `done`. A wrong status or capture register shows up in the `done` cycle itself.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE     = 2'd0,
    PH_ANNOUNCE = 2'd1,
    PH_WAIT     = 2'd2,
    PH_SELECT   = 2'd3
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic cntClear;
    logic recordTerm;
    logic captureWord;
  } dpCtrl_t;

  localparam logic [1:0] TERM_NONE   = 2'b00;
  localparam logic [1:0] TERM_ACK    = 2'b01;
  localparam logic [1:0] TERM_PERIPH = 2'b10;
  localparam logic [1:0] TERM_BUSERR = 2'b11;

endpackage

// File: rtl/bwr_term_encoder.sv
module bwr_term_encoder import bwr_pkg::*; (
  input  logic       ackIn,
  input  logic       periphValidIn,
  input  logic       busErrIn,
  output logic       termAny,
  output logic [1:0] termCode
);

  assign termAny = ackIn | periphValidIn | busErrIn;

  // bus error outranks valid-peripheral, which outranks acknowledge
  always_comb begin
    if (busErrIn)           termCode = TERM_BUSERR;
    else if (periphValidIn) termCode = TERM_PERIPH;
    else if (ackIn)         termCode = TERM_ACK;
    else                    termCode = TERM_NONE;
  end

endmodule

// File: rtl/bwr_datapath.sv
module bwr_datapath import bwr_pkg::*; #(
  parameter int ADDR_W       = 24,
  parameter int DATA_W       = 16,
  parameter int CNT_W        = 2,
  parameter bit IMPLICIT_ACK = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  dpCtrl_t           ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsProgram,
  input  logic              ackIn,
  input  logic              periphValidIn,
  input  logic              busErrIn,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              funcClass,
  output logic [CNT_W-1:0]  halfCount,
  output logic              termSeen,
  output logic [DATA_W-1:0] doneData,
  output logic [1:0]        doneStatus
);

  logic [1:0] termCode;
  logic [1:0] statusNext;

  bwr_term_encoder u_term (
    .ackIn         (ackIn),
    .periphValidIn (periphValidIn),
    .busErrIn      (busErrIn),
    .termAny       (termSeen),
    .termCode      (termCode)
  );

  assign statusNext = IMPLICIT_ACK ? TERM_NONE : termCode;

  // request latch: address and class held for the whole access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr   <= '0;
      funcClass <= 1'b0;
    end else if (ctrl.latchReq) begin
      busAddr   <= reqAddr;
      funcClass <= reqIsProgram;
    end
  end

  // half-cycle counter within the current phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              halfCount <= '0;
    else if (ctrl.cntClear) halfCount <= '0;
    else if (halfTick)      halfCount <= halfCount + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                doneStatus <= TERM_NONE;
    else if (ctrl.recordTerm) doneStatus <= statusNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 doneData <= '0;
    else if (ctrl.captureWord) doneData <= rdData;
  end

endmodule

// File: rtl/bwr_ctrl.sv
module bwr_ctrl import bwr_pkg::*; #(
  parameter int CNT_W         = 2,
  parameter int ANNOUNCE_HALF = 4,
  parameter int POLL_HALF     = 2,
  parameter int SELECT_HALF   = 4,
  parameter bit IMPLICIT_ACK  = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             halfTick,
  input  logic             reqValid,
  input  logic [CNT_W-1:0] halfCount,
  input  logic             termSeen,
  output dpCtrl_t          ctrl,
  output logic             addrStrobe,
  output logic             wordSelect,
  output logic             done
);

  localparam logic [CNT_W-1:0] ANN_LAST  = CNT_W'(ANNOUNCE_HALF - 1);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_HALF - 1);
  localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(SELECT_HALF - 1);

  phase_e           phase, phaseNext;
  logic [CNT_W-1:0] phaseLast;
  logic             phaseEnd;

  always_comb begin
    unique case (phase)
      PH_ANNOUNCE: phaseLast = ANN_LAST;
      PH_WAIT:     phaseLast = POLL_LAST;
      PH_SELECT:   phaseLast = SEL_LAST;
      default:     phaseLast = '0;
    endcase
  end

  assign phaseEnd = halfTick && (halfCount == phaseLast);

  always_comb begin
    phaseNext = phase;
    ctrl      = '0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          phaseNext     = PH_ANNOUNCE;
          ctrl.latchReq = 1'b1;
          ctrl.cntClear = 1'b1;
        end
      end
      PH_ANNOUNCE: begin
        if (phaseEnd) begin
          ctrl.cntClear = 1'b1;
          if (IMPLICIT_ACK || termSeen) begin
            phaseNext       = PH_SELECT;
            ctrl.recordTerm = 1'b1;
          end else begin
            phaseNext = PH_WAIT;
          end
        end
      end
      PH_WAIT: begin
        if (phaseEnd) begin
          ctrl.cntClear = 1'b1;
          if (termSeen) begin
            phaseNext       = PH_SELECT;
            ctrl.recordTerm = 1'b1;
          end
        end
      end
      PH_SELECT: begin
        if (phaseEnd) begin
          ctrl.cntClear    = 1'b1;
          ctrl.captureWord = 1'b1;
          phaseNext        = PH_IDLE;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= (phase == PH_SELECT) && phaseEnd;
    end
  end

  assign addrStrobe = (phase != PH_IDLE);
  assign wordSelect = (phase == PH_SELECT);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_DONE_FROM_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(wordSelect)); // R7
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && !wordSelect && reqValid) |=> addrStrobe); // R9

endmodule

// File: rtl/bus_word_reader.sv
module bus_word_reader import bwr_pkg::*; #(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 16,
  parameter int ANNOUNCE_HALF = 4,
  parameter int POLL_HALF     = 2,
  parameter int SELECT_HALF   = 4,
  parameter bit IMPLICIT_ACK  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              halfTick,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqIsProgram,
  output logic [ADDR_W-1:0] busAddr,
  output logic              funcClass,
  output logic              addrStrobe,
  output logic              wordSelect,
  input  logic              ackIn,
  input  logic              periphValidIn,
  input  logic              busErrIn,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic [DATA_W-1:0] doneData,
  output logic [1:0]        doneStatus
);

  localparam int MAX_AP  = (ANNOUNCE_HALF > POLL_HALF) ? ANNOUNCE_HALF : POLL_HALF;
  localparam int MAX_LEN = (MAX_AP > SELECT_HALF) ? MAX_AP : SELECT_HALF;
  localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

  dpCtrl_t          ctrl;
  logic [CNT_W-1:0] halfCount;
  logic             termSeen;

  bwr_ctrl #(
    .CNT_W         (CNT_W),
    .ANNOUNCE_HALF (ANNOUNCE_HALF),
    .POLL_HALF     (POLL_HALF),
    .SELECT_HALF   (SELECT_HALF),
    .IMPLICIT_ACK  (IMPLICIT_ACK)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .halfTick   (halfTick),
    .reqValid   (reqValid),
    .halfCount  (halfCount),
    .termSeen   (termSeen),
    .ctrl       (ctrl),
    .addrStrobe (addrStrobe),
    .wordSelect (wordSelect),
    .done       (done)
  );

  bwr_datapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .CNT_W        (CNT_W),
    .IMPLICIT_ACK (IMPLICIT_ACK)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .halfTick      (halfTick),
    .ctrl          (ctrl),
    .reqAddr       (reqAddr),
    .reqIsProgram  (reqIsProgram),
    .ackIn         (ackIn),
    .periphValidIn (periphValidIn),
    .busErrIn      (busErrIn),
    .rdData        (rdData),
    .busAddr       (busAddr),
    .funcClass     (funcClass),
    .halfCount     (halfCount),
    .termSeen      (termSeen),
    .doneData      (doneData),
    .doneStatus    (doneStatus)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && $past(addrStrobe)) |-> $stable(busAddr)); // R1
  AST_CLASS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && $past(addrStrobe)) |-> $stable(funcClass)); // R6
  AST_FIRST_PHASE_NO_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrStrobe) |-> !wordSelect); // R1
  AST_SELECT_AFTER_TERM: assert property (@(posedge clk) disable iff (!rstN)
    (!IMPLICIT_ACK && $rose(wordSelect)) |-> $past(ackIn || periphValidIn || busErrIn)); // R3
  AST_DONE_BUS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!addrStrobe && !wordSelect)); // R7
  AST_IMPLICIT_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (IMPLICIT_ACK && done) |-> (doneStatus == TERM_NONE)); // R4
  AST_STATUS_CODED: assert property (@(posedge clk) disable iff (!rstN)
    (!IMPLICIT_ACK && done) |-> (doneStatus != TERM_NONE)); // R8

endmodule

// File: tb/bus_word_reader_tb.sv
`timescale 1ns/1ps
module bus_word_reader_tb;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int SEL_TICKS = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          halfTick = 1'b1;
  logic          reqValidMain = 1'b0;
  logic          reqValidImp = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic          reqIsProgram = 1'b0;
  logic          ackIn = 1'b0, periphValidIn = 1'b0, busErrIn = 1'b0;
  logic [DW-1:0] rdData = '0;

  logic [AW-1:0] mAddr, iAddr;
  logic          mClass, iClass, mStrobe, iStrobe, mSel, iSel, mDone, iDone;
  logic [DW-1:0] mData, iData;
  logic [1:0]    mStat, iStat;

  int checks = 0;
  int errors = 0;
  logic useImp = 1'b0;

  always #2.5 clk = ~clk;

  bus_word_reader #(.IMPLICIT_ACK(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .reqValid(reqValidMain),
    .reqAddr(reqAddr), .reqIsProgram(reqIsProgram), .busAddr(mAddr),
    .funcClass(mClass), .addrStrobe(mStrobe), .wordSelect(mSel),
    .ackIn(ackIn), .periphValidIn(periphValidIn), .busErrIn(busErrIn),
    .rdData(rdData), .done(mDone), .doneData(mData), .doneStatus(mStat));

  bus_word_reader #(.IMPLICIT_ACK(1'b1)) u_dutImp (
    .clk(clk), .rstN(rstN), .halfTick(halfTick), .reqValid(reqValidImp),
    .reqAddr(reqAddr), .reqIsProgram(reqIsProgram), .busAddr(iAddr),
    .funcClass(iClass), .addrStrobe(iStrobe), .wordSelect(iSel),
    .ackIn(ackIn), .periphValidIn(periphValidIn), .busErrIn(busErrIn),
    .rdData(rdData), .done(iDone), .doneData(iData), .doneStatus(iStat));

  logic [AW-1:0] oAddr;
  logic          oClass, oStrobe, oSel, oDone;
  logic [DW-1:0] oData;
  logic [1:0]    oStat;
  always_comb begin
    oAddr   = useImp ? iAddr   : mAddr;
    oClass  = useImp ? iClass  : mClass;
    oStrobe = useImp ? iStrobe : mStrobe;
    oSel    = useImp ? iSel    : mSel;
    oDone   = useImp ? iDone   : mDone;
    oData   = useImp ? iData   : mData;
    oStat   = useImp ? iStat   : mStat;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // cycles with the address phase (incl. wait) when termination rises in cycle d
  function automatic int expWaitCycles(input int d);
    int extra;
    if (d <= 4) return 4;
    extra = d - 4;
    return 4 + 2 * ((extra + 1) / 2);
  endfunction

  task automatic doAccess(input bit imp, input logic [AW-1:0] addr, input bit isProg,
                          input int termDelay, input logic [2:0] termSel,
                          input logic [DW-1:0] word, input int expAnnCycles,
                          input logic [1:0] expStatus, input bit gated, input bit intrude);
    int  annCycles = 0, annTicks = 0, selTicks = 0, cyc = 0, addrBad = 0, classBad = 0;
    bit  seenDone = 1'b0, prevSel = 1'b0, tickNow = 1'b1;
    @(negedge clk);
    useImp = imp;
    halfTick = 1'b1; reqAddr = addr; reqIsProgram = isProg; rdData = word;
    {busErrIn, periphValidIn, ackIn} = 3'b000;
    if (imp) reqValidImp = 1'b1; else reqValidMain = 1'b1;
    @(negedge clk);
    reqValidImp = 1'b0; reqValidMain = 1'b0;
    while (!seenDone && cyc < 400) begin
      cyc++;
      reqValidImp = 1'b0; reqValidMain = 1'b0;
      tickNow = gated ? ~tickNow : 1'b1;
      halfTick = tickNow;
      if (oStrobe && (oAddr != addr)) addrBad++;
      if (oStrobe && (oClass != isProg)) classBad++;
      if (oDone) begin
        seenDone = 1'b1;
        check(prevSel, "R7", "done right after select", 0, 1);
        check(!oStrobe && !oSel, "R7", "strobes low at done", {oStrobe, oSel}, 0);
        check(oData == word, "R7", "doneData", oData, word);
        check(oStat == expStatus, "R8", "doneStatus", oStat, expStatus);
      end else if (oStrobe && !oSel) begin
        annCycles++;
        if (tickNow) annTicks++;
        if (annCycles >= termDelay) {busErrIn, periphValidIn, ackIn} = termSel;
        if (intrude && annCycles == 2) begin
          reqAddr = ~addr;
          if (imp) reqValidImp = 1'b1; else reqValidMain = 1'b1;
        end
      end else if (oSel) begin
        if (tickNow) selTicks++;
      end
      prevSel = oSel;
      if (!seenDone) @(negedge clk);
    end
    {busErrIn, periphValidIn, ackIn} = 3'b000;
    halfTick = 1'b1;
    check(seenDone, "R7", "access completed", seenDone, 1);
    check(addrBad == 0, "R1", "busAddr held (R5 select too)", addrBad, 0);
    check(classBad == 0, "R6", "funcClass held", classBad, 0);
    check(selTicks == SEL_TICKS, "R5", "select ticks", selTicks, SEL_TICKS);
    if (expAnnCycles >= 0)
      check(annCycles == expAnnCycles, "R2", "address+wait cycles (R3)", annCycles, expAnnCycles);
    else
      check(annTicks == 4, "R1", "address-phase ticks", annTicks, 4);
    @(negedge clk);
    check(!oDone, "R7", "done one cycle", oDone, 0);
    if (intrude) begin
      for (int k = 0; k < 3; k++) begin
        check(!oStrobe, "R9", "no second access", oStrobe, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(!mStrobe && !mSel && !mDone, "R10", "reset state main", {mStrobe, mSel, mDone}, 0);
    check(!iStrobe && !iSel && !iDone, "R10", "reset state implicit", {iStrobe, iSel, iDone}, 0);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    useImp = 1'b0;
    reqAddr = 24'h00_0ABC; reqValidMain = 1'b1;
    @(negedge clk);
    reqValidMain = 1'b0;
    @(negedge clk);
    check(mStrobe, "R1", "strobe up before reset", mStrobe, 1);
    rstN = 1'b0;
    #1;
    check(!mStrobe && !mSel && !mDone, "R10", "reset mid access", {mStrobe, mSel, mDone}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!mStrobe, "R10", "idle after reset release", mStrobe, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();                                                                    // R10
    // immediate acknowledge, data read: R1 R5 R6 R7 R8
    doAccess(1'b0, 24'h12_3456, 1'b0, 1, 3'b001, 16'hBEEF, expWaitCycles(1), 2'b01, 1'b0, 1'b0);
    // program read, ack rising on last address tick
    doAccess(1'b0, 24'hFF_0002, 1'b1, 4, 3'b001, 16'h1234, expWaitCycles(4), 2'b01, 1'b0, 1'b0);
    // R2 R3 polling: termination mid-poll and on a poll boundary
    doAccess(1'b0, 24'h00_1000, 1'b0, 5, 3'b010, 16'h5A5A, expWaitCycles(5), 2'b10, 1'b0, 1'b0);
    doAccess(1'b0, 24'h00_2000, 1'b1, 9, 3'b100, 16'hA5A5, expWaitCycles(9), 2'b11, 1'b0, 1'b0);
    doAccess(1'b0, 24'h00_3000, 1'b0, 12, 3'b001, 16'h0F0F, expWaitCycles(12), 2'b01, 1'b0, 1'b0);
    // R8 priority
    doAccess(1'b0, 24'h00_4000, 1'b0, 1, 3'b111, 16'h0001, 4, 2'b11, 1'b0, 1'b0);
    doAccess(1'b0, 24'h00_4002, 1'b0, 1, 3'b011, 16'h0002, 4, 2'b10, 1'b0, 1'b0);
    doAccess(1'b0, 24'h00_4004, 1'b0, 6, 3'b110, 16'h0003, 6, 2'b11, 1'b0, 1'b0);
    // gated half-cycle enable: tick counts must still be 4 and 4
    doAccess(1'b0, 24'h7F_FFFE, 1'b1, 1, 3'b001, 16'hC0DE, -1, 2'b01, 1'b1, 1'b0);
    // R9 request during access
    doAccess(1'b0, 24'h55_5554, 1'b0, 7, 3'b001, 16'h7777, expWaitCycles(7), 2'b01, 1'b0, 1'b1);
    // R4 implicit acknowledge: no termination at all
    doAccess(1'b1, 24'h0A_0A0A, 1'b1, 1000, 3'b000, 16'hFACE, 4, 2'b00, 1'b0, 1'b0);
    doAccess(1'b1, 24'h0B_0B0B, 1'b0, 1, 3'b100, 16'hD00D, -1, 2'b00, 1'b1, 1'b0);
    testMidReset();                                                                 // R10
    doAccess(1'b0, 24'h00_0ABC, 1'b0, 3, 3'b001, 16'h4321, 4, 2'b01, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule